// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer

This block runs single read and write accesses to an external asynchronous memory (SRAM, NOR flash or a memory-mapped peripheral) on one chip select. A host presents a request with address, byte enables, write data and a direction bit. The block accepts it while idle and walks through a setup phase, a strobe phase and a hold phase. Reads add a turnaround phase after the hold, so a slow device can release the data bus before the next access. Each phase length is in clock cycles and comes from a configuration input; a value of zero counts as one cycle.

Two strobe styles are supported. In write-enable strobing, chip select covers the whole access and the byte lines pulse only during the strobe. In chip-select strobing, the roles are swapped: the byte lines stay steady as lane enables and chip select pulses during the strobe. A memory can hold its ready/wait pin to stretch the strobe with extended wait cycles. That pin passes through a two-stage synchronizer, and the synchronizer delay fits inside a four-cycle budget for both the assertion deadline and the release. The tri-state data bus is presented as separate out, out-enable and in vectors, for the pad ring to combine.

Top module: `amc_ctrl`

## Requirements
- R1: The phase order is setup, then strobe, then hold; a read adds turnaround. Each length is its configuration value in cycles, and zero counts as one. `req_ready` is high exactly when no access is in progress, and the request is accepted on a rising edge with `req_valid` and `req_ready` both high.
- R2: With `cfg_sel_strobe`=0, `mem_cs_n` is low from the first setup cycle through the last hold cycle. `mem_be_n` equals the inverted byte enables during strobe cycles only and is all ones otherwise.
- R3: With `cfg_sel_strobe`=1, `mem_cs_n` is low during strobe cycles only. `mem_be_n` equals the inverted byte enables from the first setup cycle through the last hold cycle.
- R4: `mem_oe_n` is low during every strobe cycle (including extended ones) of a read and never otherwise. `mem_we_n` is low during every strobe cycle of a write and never otherwise.
- R5: `mem_dq_oe` is high from the first setup cycle through the last hold cycle of a write and low at all other times. While it is high, `mem_dq_o` carries the request's write data.
- R6: `mem_rnw` is 0 through setup, strobe and hold of a write and 1 at all other times. `mem_addr` holds the request address through setup, strobe and hold.
- R7: Read data is the value on `mem_dq_i` at the rising edge that ends the last strobe cycle.
- R8: `rsp_valid` is high for exactly one cycle per access. For a read it is the first hold cycle, with the captured data on `rsp_rdata`. For a write it is the cycle after the last hold cycle.
- R9: With `cfg_wait_en`=1, the strobe is extended when `mem_wait` is high at the rising edge two edges before the edge that would end the strobe, which is within the four-cycle deadline. Extension lasts until `mem_wait` is first sampled low. Hold then begins two edges after that sample, within the four-cycle release limit.
- R10: With `cfg_wait_en`=0, `mem_wait` has no effect and the strobe lasts exactly its configured length.
- R11: After reset, `mem_cs_n`, `mem_oe_n`, `mem_we_n`, `mem_rnw` and all `mem_be_n` bits are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_be | input | BE_W | Byte enables, active high |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Idle, request is accepted |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| cfg_setup | input | CNT_W | Setup cycles (0 means 1) |
| cfg_strobe | input | CNT_W | Strobe cycles (0 means 1) |
| cfg_hold | input | CNT_W | Hold cycles (0 means 1) |
| cfg_turn | input | CNT_W | Read turnaround cycles (0 means 1) |
| cfg_sel_strobe | input | 1 | 0 = write-enable strobing, 1 = chip-select strobing |
| cfg_wait_en | input | 1 | Enables strobe extension by mem_wait |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_be_n | output | BE_W | Byte strobes or byte-lane enables, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_i | input | DATA_W | Data bus input value |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_rnw | output | 1 | Direction: 1 read, 0 write |
| mem_wait | input | 1 | Asynchronous wait request, active high |

## Verification
The bench uses the default parameters: a 24-bit address, 32-bit data with four byte lanes, 4-bit phase counters and a two-stage wait synchronizer. The 4-bit counters allow all-zero lengths (to test the clamp to one cycle) and a six-cycle strobe. The six-cycle strobe leaves room to place the wait pin exactly on, and one cycle past, the latest sampling edge, and to release it during extension. Read data is driven valid only in the final strobe cycle, so a capture one edge early or late is visible.

// File: rtl/amc_pkg.sv
package amc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_XWAIT  = 3'd3,
        PH_HOLD   = 3'd4,
        PH_TURN   = 3'd5
    } amc_phase_e;

endpackage

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q[STAGES-1];

endmodule

// File: rtl/amc_seq.sv
module amc_seq
    import amc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_strobe,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic [CNT_W-1:0]  cfg_turn,
    input  logic              cfg_sel_strobe,
    input  logic              cfg_wait_en,
    input  logic              wait_s,
    input  logic [DATA_W-1:0] dq_i,
    output logic              req_ready,
    output amc_phase_e        phase,
    output logic              acc_write,
    output logic              acc_sel,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BE_W-1:0]   acc_be,
    output logic [DATA_W-1:0] acc_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        amc_phase_e        ph;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic              sel;
        logic              wen;
        logic [CNT_W-1:0]  len_strobe;
        logic [CNT_W-1:0]  len_hold;
        logic [CNT_W-1:0]  len_turn;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rsp;
    } seq_state_t;

    seq_state_t st_d, st_q;

    // Counter preload: a zero length behaves as one cycle.
    function automatic logic [CNT_W-1:0] preload(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : len - CNT_W'(1);
    endfunction

    logic last_cyc;
    logic end_strobe;

    always_comb begin
        st_d       = st_q;
        st_d.rsp   = 1'b0;
        last_cyc   = (st_q.cnt == '0);
        end_strobe = 1'b0;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.ph         = PH_SETUP;
                    st_d.cnt        = preload(cfg_setup);
                    st_d.wr         = req_write;
                    st_d.sel        = cfg_sel_strobe;
                    st_d.wen        = cfg_wait_en;
                    st_d.len_strobe = cfg_strobe;
                    st_d.len_hold   = cfg_hold;
                    st_d.len_turn   = cfg_turn;
                    st_d.addr       = req_addr;
                    st_d.be         = req_be;
                    st_d.wdata      = req_wdata;
                end
            end
            PH_SETUP: begin
                if (last_cyc) begin
                    st_d.ph  = PH_STROBE;
                    st_d.cnt = preload(st_q.len_strobe);
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_STROBE: begin
                if (last_cyc) begin
                    if (st_q.wen && wait_s) st_d.ph = PH_XWAIT;
                    else                    end_strobe = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_XWAIT: begin
                if (!wait_s) end_strobe = 1'b1;
            end
            PH_HOLD: begin
                if (last_cyc) begin
                    if (st_q.wr) begin
                        st_d.ph  = PH_IDLE;
                        st_d.rsp = 1'b1;
                    end else begin
                        st_d.ph  = PH_TURN;
                        st_d.cnt = preload(st_q.len_turn);
                    end
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_TURN: begin
                if (last_cyc) st_d.ph = PH_IDLE;
                else          st_d.cnt = st_q.cnt - CNT_W'(1);
            end
            default: st_d.ph = PH_IDLE;
        endcase

        if (end_strobe) begin
            st_d.ph  = PH_HOLD;
            st_d.cnt = preload(st_q.len_hold);
            if (!st_q.wr) begin
                st_d.rdata = dq_i;
                st_d.rsp   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.ph == PH_IDLE);
    assign phase     = st_q.ph;
    assign acc_write = st_q.wr;
    assign acc_sel   = st_q.sel;
    assign acc_addr  = st_q.addr;
    assign acc_be    = st_q.be;
    assign acc_wdata = st_q.wdata;
    assign rsp_valid = st_q.rsp;
    assign rsp_rdata = st_q.rdata;

    // A second consecutive extended cycle needs the synchronized wait seen high.
    p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_XWAIT && $past(st_q.ph) == PH_XWAIT) |-> $past(wait_s));

    p_wait_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_XWAIT) |-> st_q.wen);

endmodule

// File: rtl/amc_pin_decode.sv
module amc_pin_decode
    import amc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  amc_phase_e        phase,
    input  logic              acc_write,
    input  logic              acc_sel,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BE_W-1:0]   acc_be,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              mem_cs_n,
    output logic [BE_W-1:0]   mem_be_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_rnw
);

    logic in_strobe;
    logic in_access;

    always_comb begin
        in_strobe = (phase == PH_STROBE) || (phase == PH_XWAIT);
        in_access = (phase == PH_SETUP) || in_strobe || (phase == PH_HOLD);

        mem_cs_n  = acc_sel ? !in_strobe : !in_access;
        mem_be_n  = (acc_sel ? in_access : in_strobe) ? ~acc_be : '1;
        mem_oe_n  = !(in_strobe && !acc_write);
        mem_we_n  = !(in_strobe && acc_write);
        mem_rnw   = !(in_access && acc_write);
        mem_dq_oe = in_access && acc_write;
        mem_dq_o  = acc_wdata;
        mem_addr  = acc_addr;
    end

endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl
    import amc_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int BE_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_strobe,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic [CNT_W-1:0]  cfg_turn,
    input  logic              cfg_sel_strobe,
    input  logic              cfg_wait_en,
    output logic              mem_cs_n,
    output logic [BE_W-1:0]   mem_be_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_rnw,
    input  logic              mem_wait
);

    logic              wait_s;
    amc_phase_e        phase;
    logic              acc_write;
    logic              acc_sel;
    logic [ADDR_W-1:0] acc_addr;
    logic [BE_W-1:0]   acc_be;
    logic [DATA_W-1:0] acc_wdata;

    amc_wait_sync #(
        .STAGES (SYNC_STAGES)
    ) i_wait_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mem_wait),
        .sync_out (wait_s)
    );

    amc_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W),
        .CNT_W  (CNT_W)
    ) i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_be         (req_be),
        .req_wdata      (req_wdata),
        .cfg_setup      (cfg_setup),
        .cfg_strobe     (cfg_strobe),
        .cfg_hold       (cfg_hold),
        .cfg_turn       (cfg_turn),
        .cfg_sel_strobe (cfg_sel_strobe),
        .cfg_wait_en    (cfg_wait_en),
        .wait_s         (wait_s),
        .dq_i           (mem_dq_i),
        .req_ready      (req_ready),
        .phase          (phase),
        .acc_write      (acc_write),
        .acc_sel        (acc_sel),
        .acc_addr       (acc_addr),
        .acc_be         (acc_be),
        .acc_wdata      (acc_wdata),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata)
    );

    amc_pin_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) i_pins (
        .phase     (phase),
        .acc_write (acc_write),
        .acc_sel   (acc_sel),
        .acc_addr  (acc_addr),
        .acc_be    (acc_be),
        .acc_wdata (acc_wdata),
        .mem_cs_n  (mem_cs_n),
        .mem_be_n  (mem_be_n),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_rnw   (mem_rnw)
    );

    p_oe_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_rnw);

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_dq_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_rnw);

    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_dq_oe && mem_oe_n && mem_we_n));

endmodule

// File: tb/test_amc_ctrl.sv
module test_amc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  cfg_setup = 4'd1;
    logic [3:0]  cfg_strobe = 4'd1;
    logic [3:0]  cfg_hold = 4'd1;
    logic [3:0]  cfg_turn = 4'd1;
    logic        cfg_sel_strobe = 1'b0;
    logic        cfg_wait_en = 1'b0;
    logic        mem_cs_n;
    logic [3:0]  mem_be_n;
    logic [23:0] mem_addr;
    logic [31:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_i = '0;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic        mem_rnw;
    logic        mem_wait = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    amc_ctrl i_amc_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_be         (req_be),
        .req_wdata      (req_wdata),
        .req_ready      (req_ready),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata),
        .cfg_setup      (cfg_setup),
        .cfg_strobe     (cfg_strobe),
        .cfg_hold       (cfg_hold),
        .cfg_turn       (cfg_turn),
        .cfg_sel_strobe (cfg_sel_strobe),
        .cfg_wait_en    (cfg_wait_en),
        .mem_cs_n       (mem_cs_n),
        .mem_be_n       (mem_be_n),
        .mem_addr       (mem_addr),
        .mem_dq_o       (mem_dq_o),
        .mem_dq_oe      (mem_dq_oe),
        .mem_dq_i       (mem_dq_i),
        .mem_oe_n       (mem_oe_n),
        .mem_we_n       (mem_we_n),
        .mem_rnw        (mem_rnw),
        .mem_wait       (mem_wait)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready === 1'b1, "R11", "ready after reset", req_ready, 1);
        chk({mem_cs_n, mem_oe_n, mem_we_n, mem_rnw} === 4'hF, "R11", "strobes after reset",
            {mem_cs_n, mem_oe_n, mem_we_n, mem_rnw}, 4'hF);
        chk(mem_be_n === 4'hF, "R11", "byte lines after reset", mem_be_n, 4'hF);
        chk({mem_dq_oe, rsp_valid} === 2'b00, "R11", "bus and response after reset",
            {mem_dq_oe, rsp_valid}, 0);
    endtask

    // Runs one access and compares every pin in every cycle against a
    // schedule computed from the requirements. Cycle c is the c-th cycle
    // after the accepting edge; wait is high for cycles won..woff-1.
    task automatic run_access(input bit wr, input bit sel, input bit wen,
                              input int s, input int t, input int h, input int r,
                              input logic [23:0] a, input logic [3:0] be,
                              input logic [31:0] wd, input logic [31:0] rd,
                              input int won, input int woff,
                              input string ctag, input string stag);
        int S = (s == 0) ? 1 : s;
        int T = (t == 0) ? 1 : t;
        int H = (h == 0) ? 1 : h;
        int R = (r == 0) ? 1 : r;
        int ext = 0;
        int t_end, h_end, r_end;
        int e_cs = 0, e_be = 0, e_ctl = 0, e_bus = 0, e_dir = 0, e_rsp = 0, e_rdy = 0;
        int strobe_seen = 0;
        logic [31:0] got_rd = '0;
        if (wen && won >= 0 && won <= S + T - 2 && woff > S + T - 2)
            ext = woff + 2 - (S + T);
        t_end = S + T + ext;
        h_end = t_end + H;
        r_end = wr ? h_end : h_end + R;

        cfg_setup      = 4'(s);
        cfg_strobe     = 4'(t);
        cfg_hold       = 4'(h);
        cfg_turn       = 4'(r);
        cfg_sel_strobe = sel;
        cfg_wait_en    = wen;
        req_write      = wr;
        req_addr       = a;
        req_be         = be;
        req_wdata      = wd;
        req_valid      = 1'b1;
        @(posedge clk);

        for (int c = 1; c <= r_end + 1; c++) begin
            bit act;
            bit stb;
            bit exp_rsp;
            @(negedge clk);
            req_valid = 1'b0;
            mem_wait  = (won >= 0 && c >= won && c < woff);
            mem_dq_i  = (c == t_end) ? rd : ~rd;
            act     = (c <= h_end);
            stb     = (c > S && c <= t_end);
            exp_rsp = wr ? (c == h_end + 1) : (c == t_end + 1);
            if (mem_cs_n !== (sel ? !stb : !act)) e_cs++;
            if (mem_be_n !== (((sel ? act : stb)) ? ~be : 4'hF)) e_be++;
            if (mem_oe_n !== !(stb && !wr) || mem_we_n !== !(stb && wr)) e_ctl++;
            if (!mem_oe_n || !mem_we_n) strobe_seen++;
            if (mem_dq_oe !== (wr && act) || (wr && act && mem_dq_o !== wd)) e_bus++;
            if (mem_rnw !== !(wr && act) || (act && mem_addr !== a)) e_dir++;
            if (rsp_valid !== exp_rsp) e_rsp++;
            if (rsp_valid && !wr) got_rd = rsp_rdata;
            if (req_ready !== (c > r_end)) e_rdy++;
        end
        mem_wait = 1'b0;

        chk(e_cs == 0, ctag, "chip select cycles wrong", e_cs, 0);
        chk(e_be == 0, ctag, "byte line cycles wrong", e_be, 0);
        chk(e_ctl == 0, "R4", "oe/we cycles wrong", e_ctl, 0);
        chk(e_bus == 0, "R5", "data bus drive cycles wrong", e_bus, 0);
        chk(e_dir == 0, "R6", "direction/address cycles wrong", e_dir, 0);
        chk(e_rsp == 0, "R8", "response pulse cycles wrong", e_rsp, 0);
        chk(e_rdy == 0, "R1", "ready/phase length cycles wrong", e_rdy, 0);
        chk(strobe_seen == T + ext, stag, "strobe length", strobe_seen, T + ext);
        if (!wr) chk(got_rd === rd, "R7", "captured read data", got_rd, rd);
    endtask

    task automatic t_write_we_mode();
        run_access(1'b1, 1'b0, 1'b0, 2, 3, 2, 1, 24'h12_3456, 4'b1111,
                   32'hDEAD_BEEF, 32'h0, -1, 0, "R2", "R1");
    endtask

    task automatic t_read_we_mode();
        run_access(1'b0, 1'b0, 1'b0, 1, 2, 1, 2, 24'hAB_0010, 4'b0011,
                   32'h0, 32'hCAFE_F00D, -1, 0, "R2", "R1");
    endtask

    task automatic t_write_sel_mode();
        run_access(1'b1, 1'b1, 1'b0, 1, 1, 1, 1, 24'h00_0F00, 4'b0101,
                   32'h1357_9BDF, 32'h0, -1, 0, "R3", "R1");
    endtask

    task automatic t_read_sel_zero_lengths();
        run_access(1'b0, 1'b1, 1'b0, 0, 0, 0, 0, 24'hFF_FFFC, 4'b1000,
                   32'h0, 32'h8642_0ACE, -1, 0, "R3", "R1");
    endtask

    task automatic t_wait_extend();
        run_access(1'b0, 1'b0, 1'b1, 2, 6, 1, 1, 24'h55_AA00, 4'b1111,
                   32'h0, 32'h0BAD_CAFE, 3, 10, "R2", "R9");
    endtask

    task automatic t_wait_disabled();
        run_access(1'b0, 1'b1, 1'b0, 2, 6, 1, 1, 24'h55_AA04, 4'b1111,
                   32'h0, 32'h7777_1111, 3, 10, "R3", "R10");
    endtask

    task automatic t_wait_deadline_edge();
        run_access(1'b1, 1'b0, 1'b1, 2, 6, 2, 1, 24'h01_0203, 4'b1100,
                   32'hA5A5_5A5A, 32'h0, 6, 7, "R2", "R9");
    endtask

    task automatic t_wait_too_late();
        run_access(1'b1, 1'b1, 1'b1, 2, 6, 1, 1, 24'h01_0207, 4'b0010,
                   32'h3C3C_C3C3, 32'h0, 7, 12, "R3", "R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_we_mode();
        t_read_we_mode();
        t_write_sel_mode();
        t_read_sel_zero_lengths();
        t_wait_extend();
        t_wait_disabled();
        t_wait_deadline_edge();
        t_wait_too_late();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule